// File: doc/BRIEF.md
# Streaming Multi-Segment CRC Appender

This block takes a serial bit stream, one bit per handshake, and cuts each frame into equal segments. It computes a cyclic redundancy check over each segment and inserts that segment's checksum into the output stream right after the segment's last data bit. Data bits pass through unchanged, and the checksum bits follow them on the same serial output.

Every algorithm choice is fixed at elaboration. These choices are the generator polynomial and its degree, the register start value, and whether the register uses the direct (feedback-injected) or the augmented (shift-in plus trailing zeros) update. They also cover whether each input byte enters the register in reversed bit order, whether the remainder is mirrored, and the mask XORed onto the result. Both sides use a valid/ready handshake with frame start and end markers. An end marker that arrives partway through a segment flags an error, and the partial segment still gets its checksum.

Top module: `crc_append_stream`

## Requirements
- R1: A frame of m input bits made of NSEG segments of SEG_LEN bits produces exactly m + NSEG*DEG output bits, and each segment's DEG checksum bits follow it with no gap in the stream.
- R2: With DIRECT=1, each message bit is XORed with the register MSB to form the feedback. The register shifts left, and when the feedback is 1 the low DEG bits of POLY are XORed in. POLY is a (DEG+1)-bit descending-power vector whose MSB is the z^DEG term. Example: POLY=9'h107 with a zero start value, segment bits 0x0001 sent MSB first, gives checksum 8'h07.
- R3: With DIRECT=0, message bits shift in at the register LSB, with feedback from the register MSB. DEG zero bits then pass through the register before the remainder is taken. in_ready and out_valid stay low during those DEG cycles.
- R4: With REFL_IN=1, the bits of each 8-bit group enter the register last-received first. The first-received bit is taken as the byte MSB. Output data bits keep their arrival order and values.
- R5: With REFL_OUT=1, the remainder is bit-reversed end to end, and the XOR with XOR_MASK is applied after that reversal. An all-zero mask leaves the checksum as it is.
- R6: The register is loaded with INIT_VAL at the start of every segment, so equal segments yield equal checksums.
- R7: Checksum bits leave MSB first, and in_ready is low while they are emitted. With DIRECT=1, the first checksum bit is offered in the cycle after the last segment bit is accepted.
- R8: When out_ready is low, the register and the counters hold their state, and a checksum bit on the output stays stable. No bit is lost or duplicated.
- R9: out_sof marks the first data bit of a frame. out_eof marks the last checksum bit of the last segment.
- R10: If in_eof is accepted at a bit that is not the last of a segment, frame_err pulses high for one cycle. The partial segment is then closed with the checksum of its bits. A frame that ends on a segment boundary leaves frame_err low.
- R11: During reset out_valid is low. After reset in_ready follows out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Input bit accepted this cycle when valid |
| in_bit | input | 1 | Serial data bit |
| in_sof | input | 1 | First bit of a frame |
| in_eof | input | 1 | Last bit of a frame |
| out_valid | output | 1 | Output bit offered |
| out_ready | input | 1 | Downstream accepts the output bit |
| out_bit | output | 1 | Serial data or checksum bit |
| out_sof | output | 1 | First output bit of a frame |
| out_eof | output | 1 | Last checksum bit of the frame |
| frame_err | output | 1 | One-cycle pulse for an end marker inside a segment |

## Verification
The checker watches the control side on every cycle. It confirms that each checksum run is exactly DEG bits long and that the input is blocked while checksum and zero-fill cycles run. It also checks that a stalled checksum bit holds steady, that the end marker sits only on a checksum bit, and that the error pulse follows a mid-segment end marker and nothing else. Checksum values depend on the algorithm variant and the data, so only the bench scenarios can show them: they compare whole output streams against an independent bit-serial model for both register algorithms, with reflections and a final mask, with and without backpressure, and for a truncated frame.

// File: rtl/crc_app_pkg.sv
package crc_app_pkg;
  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_AUG  = 2'd1,
    ST_CSUM = 2'd2
  } crc_st_e;
endpackage

// File: rtl/crc_step_net.sv
// Applies up to eight serial register updates in one cycle; bits_i[0] first.
module crc_step_net #(
  parameter int unsigned   DEG    = 8,
  parameter logic [DEG:0]  POLY   = 9'h107,
  parameter bit            DIRECT = 1'b1
) (
  input  logic [DEG-1:0] crc_i,
  input  logic [7:0]     bits_i,
  input  logic [3:0]     nbits_i,
  output logic [DEG-1:0] crc_o
);
  localparam logic [DEG-1:0] TAPS = POLY[DEG-1:0];

  generate
    if (DIRECT) begin : g_direct
      always_comb begin
        logic [DEG-1:0] c;
        c = crc_i;
        for (int i = 0; i < 8; i++) begin
          if (4'(i) < nbits_i)
            c = {c[DEG-2:0], 1'b0} ^ ((c[DEG-1] ^ bits_i[i]) ? TAPS : '0);
        end
        crc_o = c;
      end
    end else begin : g_augmented
      always_comb begin
        logic [DEG-1:0] c;
        c = crc_i;
        for (int i = 0; i < 8; i++) begin
          if (4'(i) < nbits_i)
            c = {c[DEG-2:0], bits_i[i]} ^ (c[DEG-1] ? TAPS : '0);
        end
        crc_o = c;
      end
    end
  endgenerate
endmodule

// File: rtl/crc_out_shape.sv
// Optional end-to-end mirror of the remainder, then the final mask.
module crc_out_shape #(
  parameter int unsigned     DEG   = 8,
  parameter bit              REFL  = 1'b0,
  parameter logic [DEG-1:0]  XMASK = '0
) (
  input  logic [DEG-1:0] crc_i,
  output logic [DEG-1:0] csum_o
);
  logic [DEG-1:0] ordered;

  generate
    if (REFL) begin : g_mirror
      for (genvar i = 0; i < DEG; i++) begin : g_bit
        assign ordered[i] = crc_i[DEG-1-i];
      end
    end else begin : g_keep
      assign ordered = crc_i;
    end
  endgenerate

  assign csum_o = ordered ^ XMASK;
endmodule

// File: rtl/crc_append_stream.sv
module crc_append_stream
  import crc_app_pkg::*;
#(
  parameter int unsigned    DEG      = 8,
  parameter logic [DEG:0]   POLY     = 9'h107,
  parameter logic [DEG-1:0] INIT_VAL = '0,
  parameter bit             DIRECT   = 1'b1,
  parameter bit             REFL_IN  = 1'b0,
  parameter bit             REFL_OUT = 1'b0,
  parameter logic [DEG-1:0] XOR_MASK = '0,
  parameter int unsigned    SEG_LEN  = 16,
  parameter int unsigned    NSEG     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_sof,
  input  logic in_eof,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_sof,
  output logic out_eof,
  output logic frame_err
);
  localparam int BW = $clog2(SEG_LEN + 1);
  localparam int SW = $clog2(NSEG + 1);
  localparam int OW = $clog2(DEG + 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(SEG_LEN - 1);
  localparam logic [SW-1:0] SEG_LAST = SW'(NSEG - 1);
  localparam logic [OW-1:0] CNT_LAST = OW'(DEG - 1);

  crc_st_e        st_q, st_d;
  logic [BW-1:0]  bit_q, bit_d, bit_eff;
  logic [SW-1:0]  seg_q, seg_d, seg_eff;
  logic [OW-1:0]  cnt_q, cnt_d;
  logic [DEG-1:0] crc_q, crc_d, crc_base, core_in, core_out, csum_w;
  logic [7:0]     byte_q, byte_d, byte_base, byte_n, feed_bits, core_bits;
  logic [3:0]     bcnt_q, bcnt_d, bcnt_base, nb_w, feed_n, core_n;
  logic           last_q, last_d, err_q, err_d;
  logic           in_data, in_aug, sof_hit, acc, at_seg_last, seg_end, frame_end, flush;

  // ---- handshake and stream muxing ----
  assign in_data   = (st_q == ST_DATA);
  assign in_aug    = (st_q == ST_AUG);
  assign in_ready  = in_data & out_ready;
  assign acc       = in_valid & in_ready;
  assign sof_hit   = in_valid & in_sof;

  assign bit_eff   = sof_hit ? '0 : bit_q;
  assign seg_eff   = sof_hit ? '0 : seg_q;
  assign crc_base  = sof_hit ? INIT_VAL : crc_q;
  assign byte_base = sof_hit ? '0 : byte_q;
  assign bcnt_base = sof_hit ? '0 : bcnt_q;

  assign at_seg_last = (bit_eff == BIT_LAST);
  assign seg_end     = acc & (at_seg_last | in_eof);
  assign frame_end   = acc & (in_eof | (at_seg_last & (seg_eff == SEG_LAST)));

  assign out_valid = in_data ? in_valid : (st_q == ST_CSUM);
  assign out_bit   = in_data ? in_bit : csum_w[CNT_LAST - cnt_q];
  assign out_sof   = in_data & in_valid & (seg_eff == '0) & (bit_eff == '0);
  assign out_eof   = (st_q == ST_CSUM) & last_q & (cnt_q == CNT_LAST);
  assign frame_err = err_q;

  // ---- byte gathering for the register feed ----
  assign byte_n = {byte_base[6:0], in_bit};
  assign nb_w   = bcnt_base + 4'd1;

  generate
    if (REFL_IN) begin : g_byte_reflect
      assign flush     = (nb_w == 4'd8) | seg_end;
      assign feed_bits = byte_n;
      assign feed_n    = flush ? nb_w : 4'd0;
    end else begin : g_bit_serial
      assign flush     = 1'b1;
      assign feed_bits = {7'b0, in_bit};
      assign feed_n    = 4'd1;
    end
  endgenerate

  assign core_in   = in_aug ? crc_q : crc_base;
  assign core_bits = in_aug ? 8'h00 : feed_bits;
  assign core_n    = in_aug ? 4'd1 : (acc ? feed_n : 4'd0);

  crc_step_net #(.DEG(DEG), .POLY(POLY), .DIRECT(DIRECT)) u_step (
    .crc_i  (core_in),
    .bits_i (core_bits),
    .nbits_i(core_n),
    .crc_o  (core_out)
  );

  crc_out_shape #(.DEG(DEG), .REFL(REFL_OUT), .XMASK(XOR_MASK)) u_shape (
    .crc_i (crc_q),
    .csum_o(csum_w)
  );

  // ---- next state ----
  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    seg_d  = seg_q;
    cnt_d  = cnt_q;
    crc_d  = crc_q;
    byte_d = byte_q;
    bcnt_d = bcnt_q;
    last_d = last_q;
    err_d  = 1'b0;
    unique case (st_q)
      ST_DATA: begin
        if (acc) begin
          crc_d  = core_out;
          byte_d = byte_n;
          bcnt_d = flush ? 4'd0 : nb_w;
          if (seg_end) begin
            bit_d  = '0;
            cnt_d  = '0;
            last_d = frame_end;
            err_d  = in_eof & ~at_seg_last;
            seg_d  = frame_end ? '0 : SW'(seg_eff + 1'b1);
            st_d   = DIRECT ? ST_CSUM : ST_AUG;
          end else begin
            bit_d = BW'(bit_eff + 1'b1);
            seg_d = seg_eff;
          end
        end
      end
      ST_AUG: begin
        crc_d = core_out;
        if (cnt_q == CNT_LAST) begin
          cnt_d = '0;
          st_d  = ST_CSUM;
        end else begin
          cnt_d = OW'(cnt_q + 1'b1);
        end
      end
      ST_CSUM: begin
        if (out_ready) begin
          if (cnt_q == CNT_LAST) begin
            cnt_d = '0;
            crc_d = INIT_VAL;
            st_d  = ST_DATA;
          end else begin
            cnt_d = OW'(cnt_q + 1'b1);
          end
        end
      end
      default: st_d = ST_DATA;
    endcase
  end

  // ---- registers ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_DATA;
      bit_q  <= '0;
      seg_q  <= '0;
      cnt_q  <= '0;
      crc_q  <= INIT_VAL;
      byte_q <= '0;
      bcnt_q <= '0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      seg_q  <= seg_d;
      cnt_q  <= cnt_d;
      crc_q  <= crc_d;
      byte_q <= byte_d;
      bcnt_q <= bcnt_d;
      last_q <= last_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/crc_append_chk.sv
module crc_append_chk
  import crc_app_pkg::*;
#(
  parameter int unsigned DEG     = 8,
  parameter int unsigned SEG_LEN = 16
) (
  input logic    clk,
  input logic    rst_n,
  input logic    in_valid,
  input logic    in_ready,
  input logic    in_sof,
  input logic    in_eof,
  input logic    out_valid,
  input logic    out_ready,
  input logic    out_bit,
  input logic    out_eof,
  input logic    frame_err,
  input crc_st_e st_q
);
  int  run_q;
  int  pos_q;
  int  pos_eff;
  logic acc, in_csum, short_end;

  assign acc       = in_valid & in_ready;
  assign in_csum   = (st_q == ST_CSUM);
  assign pos_eff   = in_sof ? 0 : pos_q;
  assign short_end = acc & in_eof & (pos_eff != int'(SEG_LEN) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 0;
      pos_q <= 0;
    end else begin
      if (!in_csum) run_q <= 0;
      else if (out_valid && out_ready) run_q <= run_q + 1;
      if (acc) pos_q <= (in_eof || pos_eff == int'(SEG_LEN) - 1) ? 0 : pos_eff + 1;
    end
  end

  // R1: a checksum run never exceeds DEG bits and always completes DEG bits
  p_csum_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_csum |-> run_q < int'(DEG));
  p_csum_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_csum) |-> $past(run_q) == int'(DEG) - 1);
  // R3: zero-fill cycles neither accept nor emit
  p_aug_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_AUG) |-> (!in_ready && !out_valid));
  // R7: input blocked while checksum bits are offered
  p_csum_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_csum |-> (out_valid && !in_ready));
  // R8: a stalled checksum bit holds
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_csum && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_eof)));
  // R9: end marker only on an offered checksum bit
  p_eof_place_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> (out_valid && in_csum));
  // R10: error pulse exactly after a mid-segment end marker
  p_err_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
    short_end |=> frame_err);
  p_err_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !short_end |=> !frame_err);
endmodule

bind crc_append_stream crc_append_chk #(.DEG(DEG), .SEG_LEN(SEG_LEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_sof   (in_sof),
  .in_eof   (in_eof),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_bit  (out_bit),
  .out_eof  (out_eof),
  .frame_err(frame_err),
  .st_q     (st_q)
);

// File: tb/crc_append_stream_tb_top.sv
module crc_append_stream_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEG  = 8;
  localparam int SEG  = 16;
  localparam int NSEG = 2;
  localparam logic [8:0] POLY_U [2] = '{9'h107, 9'h131};
  localparam logic [7:0] INIT_U [2] = '{8'h00, 8'hFF};
  localparam bit         DIR_U  [2] = '{1'b1, 1'b0};
  localparam bit         RIN_U  [2] = '{1'b0, 1'b1};
  localparam bit         ROUT_U [2] = '{1'b0, 1'b1};
  localparam logic [7:0] XOR_U  [2] = '{8'h00, 8'hA5};

  // stimulus table: {unit, backpressure, 32-bit frame sent MSB first}
  localparam int NVEC = 6;
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 32'h0001_0001},
    {1'b0, 1'b1, 32'hDEAD_BEEF},
    {1'b0, 1'b0, 32'h0000_0000},
    {1'b1, 1'b0, 32'h1234_5678},
    {1'b1, 1'b1, 32'hFFFF_0000},
    {1'b1, 1'b0, 32'hA5A5_3C3C}
  };

  logic clk, rst_n;
  logic iv [2], ib [2], isof [2], ieof [2], ordy [2];
  logic ir [2], ov [2], ob [2], osof [2], oeof [2], ferr [2];
  bit   bp [2];

  int checks = 0, fails = 0, cyc = 0;
  logic cap [2][512];
  int   capcyc [2][512];
  int   ncap [2] = '{0, 0};
  int   eofidx [2] = '{-1, -1};
  int   sofidx [2] = '{-1, -1};
  int   errcnt [2] = '{0, 0};
  logic exp_b [256];
  int   exp_n;

  crc_append_stream #(.DEG(DEG), .POLY(POLY_U[0]), .INIT_VAL(INIT_U[0]), .DIRECT(DIR_U[0]),
    .REFL_IN(RIN_U[0]), .REFL_OUT(ROUT_U[0]), .XOR_MASK(XOR_U[0]), .SEG_LEN(SEG), .NSEG(NSEG)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[0]), .in_ready(ir[0]), .in_bit(ib[0]),
    .in_sof(isof[0]), .in_eof(ieof[0]), .out_valid(ov[0]), .out_ready(ordy[0]),
    .out_bit(ob[0]), .out_sof(osof[0]), .out_eof(oeof[0]), .frame_err(ferr[0]));

  crc_append_stream #(.DEG(DEG), .POLY(POLY_U[1]), .INIT_VAL(INIT_U[1]), .DIRECT(DIR_U[1]),
    .REFL_IN(RIN_U[1]), .REFL_OUT(ROUT_U[1]), .XOR_MASK(XOR_U[1]), .SEG_LEN(SEG), .NSEG(NSEG)) dut_refl (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[1]), .in_ready(ir[1]), .in_bit(ib[1]),
    .in_sof(isof[1]), .in_eof(ieof[1]), .out_valid(ov[1]), .out_ready(ordy[1]),
    .out_bit(ob[1]), .out_sof(osof[1]), .out_eof(oeof[1]), .frame_err(ferr[1]));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    for (int u = 0; u < 2; u++) ordy[u] = bp[u] ? ((cyc % 3) != 1) : 1'b1;
  end

  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      for (int u = 0; u < 2; u++) begin
        if (ov[u] === 1'b1 && ordy[u] === 1'b1) begin
          cap[u][ncap[u]] = ob[u];
          capcyc[u][ncap[u]] = cyc;
          if (oeof[u]) eofidx[u] = ncap[u];
          if (osof[u]) sofidx[u] = ncap[u];
          ncap[u] = ncap[u] + 1;
        end
        if (ferr[u] === 1'b1) errcnt[u] = errcnt[u] + 1;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    fails = fails + 1;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] mstep(input int u, input logic [7:0] c, input logic b);
    logic fb;
    if (DIR_U[u]) begin
      fb = c[7] ^ b;
      c = {c[6:0], 1'b0};
    end else begin
      fb = c[7];
      c = {c[6:0], b};
    end
    if (fb) c = c ^ POLY_U[u][7:0];
    return c;
  endfunction

  task automatic build_exp(input int u, input logic [63:0] d, input int m);
    int pos;
    pos = 0;
    exp_n = 0;
    while (pos < m) begin
      int len;
      logic [7:0] c, r;
      len = (m - pos < SEG) ? m - pos : SEG;
      c = INIT_U[u];
      for (int k = 0; k < len; k++) begin
        exp_b[exp_n] = d[m-1-(pos+k)];
        exp_n = exp_n + 1;
      end
      if (RIN_U[u]) begin
        for (int b = 0; b < len; b += 8) begin
          int nb;
          nb = (len - b < 8) ? len - b : 8;
          for (int j = nb - 1; j >= 0; j--) c = mstep(u, c, d[m-1-(pos+b+j)]);
        end
      end else begin
        for (int k = 0; k < len; k++) c = mstep(u, c, d[m-1-(pos+k)]);
      end
      if (!DIR_U[u]) for (int k = 0; k < DEG; k++) c = mstep(u, c, 1'b0);
      r = c;
      if (ROUT_U[u]) for (int k = 0; k < 8; k++) r[k] = c[7-k];
      r = r ^ XOR_U[u];
      for (int k = 7; k >= 0; k--) begin
        exp_b[exp_n] = r[k];
        exp_n = exp_n + 1;
      end
      pos = pos + len;
    end
  endtask

  task automatic send(input int u, input logic [63:0] d, input int m);
    for (int k = 0; k < m; k++) begin
      bit got;
      iv[u] = 1'b1;
      ib[u] = d[m-1-k];
      isof[u] = (k == 0);
      ieof[u] = (k == m - 1);
      got = 1'b0;
      while (!got) begin
        #(CLK_PERIOD/4);
        got = (ir[u] === 1'b1);
        @(negedge clk);
      end
    end
    iv[u] = 1'b0;
    isof[u] = 1'b0;
    ieof[u] = 1'b0;
  endtask

  task automatic wait_done(input int u, input int target);
    for (int t = 0; t < 400; t++) begin
      if (ncap[u] >= target) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic int mismatches(input int u, input int base);
    int n;
    n = 0;
    for (int k = 0; k < exp_n; k++) if (cap[u][base+k] !== exp_b[k]) n++;
    return n;
  endfunction

  function automatic logic [7:0] cap_byte(input int u, input int at);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[7-k] = cap[u][at+k];
    return v;
  endfunction

  initial begin
    for (int u = 0; u < 2; u++) begin
      iv[u] = 1'b0; ib[u] = 1'b0; isof[u] = 1'b0; ieof[u] = 1'b0; bp[u] = 1'b0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    chk(ov[0] === 1'b0 && ov[1] === 1'b0, "R11", "out_valid in reset", {ov[0], ov[1]}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #(CLK_PERIOD/4);
    chk(ir[0] === 1'b1 && ir[1] === 1'b1, "R11", "in_ready after reset", {ir[0], ir[1]}, 2'b11);
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      int u, base, e0, mm;
      string req;
      u = int'(VEC[i][33]);
      bp[u] = VEC[i][32];
      base = ncap[u];
      e0 = errcnt[u];
      build_exp(u, {32'b0, VEC[i][31:0]}, 32);
      send(u, {32'b0, VEC[i][31:0]}, 32);
      wait_done(u, base + exp_n);
      req = VEC[i][32] ? "R8" : (u == 1 ? "R5" : "R2");
      chk(ncap[u] - base == 32 + NSEG*DEG, "R1", "output length", ncap[u] - base, 32 + NSEG*DEG);
      mm = mismatches(u, base);
      chk(mm == 0, req, "stream mismatches", mm, 0);
      chk(eofidx[u] == base + exp_n - 1 && sofidx[u] == base, "R9", "sof/eof position",
          eofidx[u] - base, exp_n - 1);
      chk(errcnt[u] == e0, "R10", "no error on full frame", errcnt[u] - e0, 0);
      if (u == 1) begin
        logic [15:0] d16;
        for (int k = 0; k < 16; k++) d16[15-k] = cap[u][base+k];
        chk(d16 == VEC[i][31:16], "R4", "data passthrough", d16, VEC[i][31:16]);
      end
      if (i == 0) begin
        chk(cap_byte(0, base + 16) == 8'h07, "R7", "first checksum MSB first", cap_byte(0, base + 16), 8'h07);
        chk(cap_byte(0, base + 40) == 8'h07, "R6", "second segment reload", cap_byte(0, base + 40), 8'h07);
        chk(capcyc[0][base+16] - capcyc[0][base+15] == 1, "R7", "direct checksum follows at once",
            capcyc[0][base+16] - capcyc[0][base+15], 1);
      end
      if (i == 3) begin
        chk(capcyc[1][base+16] - capcyc[1][base+15] == DEG + 1, "R3", "zero-fill gap",
            capcyc[1][base+16] - capcyc[1][base+15], DEG + 1);
      end
    end

    // R10: end marker inside the second segment
    begin
      int base, e0, mm;
      bp[0] = 1'b0;
      base = ncap[0];
      e0 = errcnt[0];
      build_exp(0, 64'hABCDE, 20);
      send(0, 64'hABCDE, 20);
      wait_done(0, base + exp_n);
      chk(errcnt[0] - e0 == 1, "R10", "error pulse count", errcnt[0] - e0, 1);
      chk(ncap[0] - base == 20 + 2*DEG, "R10", "truncated length", ncap[0] - base, 20 + 2*DEG);
      mm = mismatches(0, base);
      chk(mm == 0, "R10", "truncated stream mismatches", mm, 0);
      chk(eofidx[0] == base + exp_n - 1, "R9", "eof on truncated frame", eofidx[0] - base, exp_n - 1);
    end

    summary();
    $finish;
  end
endmodule